// File: doc/BRIEF.md
# Multi-Pipe Receive Packet FIFO

This block buffers received packets for a receiver that listens on up to six logical data pipes. Each pipe owns a small payload-width register, written through a simple configuration port. When the upstream logic announces a packet with a start strobe and a pipe index, the block looks up that pipe's width. It then captures exactly that many bytes from the incoming byte stream into a shared store of three packet slots. Each slot keeps the packet's pipe number and byte count next to its payload.

Packets leave in arrival order, whichever pipe they came from. The read side shows the pipe number and length of the oldest packet as soon as the packet is stored, before any byte is read. Each read strobe steps through the bytes, and the slot is released only when its final byte has been consumed. Two cases are refused and reported by one-cycle error pulses: a packet aimed at a pipe with an illegal width, and a packet that arrives while all slots are taken. A flush input drops everything at once.

Top module: `rxq_packet_fifo`

## Requirements
- R1: Each of the six pipes (index 0..5) has a width register that resets to 0. A configuration write stores only bits 5:0, and bits 7:6 always read back as 0. A write or read with a select of 6 or 7 changes nothing and reads 0.
- R2: A packet started on a pipe whose width W is 1..32 is stored with that pipe number and length W, and its bytes are kept in arrival order.
- R3: Bytes that arrive after the first W bytes of a packet are not stored, and the packet is still accepted.
- R4: A start on a pipe with width 0, a width above 32, or a pipe index of 6 or 7 discards the whole packet. err_len is then high for one cycle, the cycle after the start.
- R5: A packet whose end strobe comes with fewer than W bytes received is discarded, and err_len is high the cycle after the end strobe.
- R6: The block holds at most three packets. rx_full is 1 with three stored and rx_empty is 1 with none, and both reflect a store or a release from the following cycle on. Reset leaves the block empty with no error pulse.
- R7: A start while rx_full is 1 discards the whole packet, raises err_ovf the next cycle, and leaves the stored packets unchanged.
- R8: While a packet is stored, rd_pipe and rd_len describe the oldest one from before its first byte is read. rd_data shows the byte at the current read position, and rd_last is 1 on its final byte.
- R9: rd_next advances the read position. The packet is released only when rd_next arrives with rd_last high, and a partial read leaves it at the head with its read position kept.
- R10: Packets from different pipes are read out in the order their end strobes were accepted.
- R11: flush empties all slots in one cycle, resets the read position, aborts a packet being captured, and takes priority over a same-cycle commit.
- R12: rd_next while empty has no effect, and rd_data reads 0 while empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear all stored packets |
| cfg_we | input | 1 | Width register write strobe |
| cfg_sel | input | 3 | Pipe select for configuration access |
| cfg_wdata | input | 8 | Width register write data |
| cfg_rdata | output | 8 | Width register read data for cfg_sel |
| wr_start | input | 1 | Start of incoming packet |
| wr_pipe | input | 3 | Pipe index, sampled with wr_start |
| wr_valid | input | 1 | Incoming byte valid |
| wr_data | input | 8 | Incoming byte |
| wr_end | input | 1 | End of incoming packet (may coincide with the last byte) |
| rd_next | input | 1 | Consume the current read byte |
| err_len | output | 1 | Pulse: packet dropped for illegal width or short length |
| err_ovf | output | 1 | Pulse: packet dropped because the store was full |
| rx_full | output | 1 | Three packets stored |
| rx_empty | output | 1 | No packet stored |
| rd_pipe | output | 3 | Pipe number of the head packet |
| rd_len | output | 6 | Byte count of the head packet |
| rd_data | output | 8 | Byte at the current read position |
| rd_last | output | 1 | Current byte is the head packet's final byte |

## Verification
The bench covers the width limits of 1 and 32, a packet longer than its width, and a packet shorter than its width. A design that counted bytes wrongly would store a truncated or padded payload, or would miss the short-packet error. Filling all three slots and then sending a fourth packet exposes a design that overwrites the head or lets rx_full drop. A partial read followed by more traffic catches a head popped too early or a read index that was lost. Flushes in the middle of a capture, in the same cycle as a commit, and after a partial read catch designs that leave a ghost packet behind or a stale read position.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int RXQ_PIPE_W = 3;
    localparam int RXQ_LEN_W  = 6;
    localparam int RXQ_CFG_W  = 8;

    typedef struct packed {
        logic [RXQ_PIPE_W-1:0] pipe;
        logic [RXQ_LEN_W-1:0]  len;
    } rxq_desc_t;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_FILL = 2'd1,
        WR_SKIP = 2'd2
    } rxq_wr_state_e;

    function automatic logic rxq_len_ok(input logic [RXQ_LEN_W-1:0] len, input int max_len);
        return (len != '0) && (int'(len) <= max_len);
    endfunction

    function automatic int rxq_wrap_inc(input int v, input int n);
        return (v >= n - 1) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/rxq_width_regs.sv
module rxq_width_regs
    import rxq_pkg::*;
#(
    parameter int NUM_PIPES = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [RXQ_PIPE_W-1:0] cfg_sel,
    input  logic [RXQ_CFG_W-1:0]  cfg_wdata,
    output logic [RXQ_CFG_W-1:0]  cfg_rdata,
    input  logic [RXQ_PIPE_W-1:0] look_pipe,
    output logic [RXQ_LEN_W-1:0]  look_len,
    output logic                  look_known
);

    logic [RXQ_LEN_W-1:0] width_arr [NUM_PIPES];
    logic                 unused_rsvd;

    assign unused_rsvd = ^cfg_wdata[RXQ_CFG_W-1:RXQ_LEN_W];

    generate
        for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
            logic [RXQ_LEN_W-1:0] w_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    w_q <= '0;
                end else if (cfg_we && (int'(cfg_sel) == p)) begin
                    w_q <= cfg_wdata[RXQ_LEN_W-1:0];
                end
            end
            assign width_arr[p] = w_q;
        end
    endgenerate

    always_comb begin
        cfg_rdata  = '0;
        look_len   = '0;
        look_known = 1'b0;
        for (int p = 0; p < NUM_PIPES; p++) begin
            if (int'(cfg_sel) == p) begin
                cfg_rdata = RXQ_CFG_W'(width_arr[p]);
            end
            if (int'(look_pipe) == p) begin
                look_len   = width_arr[p];
                look_known = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxq_wr_ctrl.sv
module rxq_wr_ctrl
    import rxq_pkg::*;
#(
    parameter int NUM_PIPES = 6,
    parameter int MAX_BYTES = 32,
    parameter int BYTE_W    = 8,
    localparam int IDX_W    = $clog2(MAX_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  wr_start,
    input  logic [RXQ_PIPE_W-1:0] wr_pipe,
    input  logic                  wr_valid,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  wr_end,
    input  logic [RXQ_LEN_W-1:0]  pipe_len,
    input  logic                  pipe_known,
    input  logic                  fifo_full,
    output logic                  byte_we,
    output logic [IDX_W-1:0]      byte_idx,
    output logic [BYTE_W-1:0]     byte_data,
    output logic                  commit,
    output rxq_desc_t             commit_desc,
    output logic                  err_len,
    output logic                  err_ovf
);

    rxq_wr_state_e        st_q;
    rxq_desc_t            cur_q;
    logic [RXQ_LEN_W-1:0] cnt_q;
    logic [RXQ_LEN_W-1:0] got;
    logic                 take;
    logic                 end_fill;
    logic                 short_end;
    logic                 start_bad;
    logic                 start_ovf;

    always_comb begin
        take      = (st_q == WR_FILL) && wr_valid && !wr_start && (cnt_q < cur_q.len);
        got       = cnt_q + RXQ_LEN_W'(take);
        end_fill  = (st_q == WR_FILL) && wr_end && !wr_start;
        commit    = end_fill && (got == cur_q.len) && !flush;
        short_end = end_fill && (got != cur_q.len) && !flush;
        start_bad = wr_start && !(pipe_known && rxq_len_ok(pipe_len, MAX_BYTES));
        start_ovf = wr_start && !start_bad && fifo_full;
    end

    assign byte_we     = take && !flush;
    assign byte_idx    = cnt_q[IDX_W-1:0];
    assign byte_data   = wr_data;
    assign commit_desc = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= WR_IDLE;
            cur_q   <= '0;
            cnt_q   <= '0;
            err_len <= 1'b0;
            err_ovf <= 1'b0;
        end else begin
            err_len <= !flush && (start_bad || short_end);
            err_ovf <= !flush && start_ovf;
            if (flush) begin
                st_q  <= WR_IDLE;
                cnt_q <= '0;
            end else if (wr_start) begin
                st_q       <= (start_bad || start_ovf) ? WR_SKIP : WR_FILL;
                cur_q.pipe <= wr_pipe;
                cur_q.len  <= pipe_len;
                cnt_q      <= '0;
            end else begin
                unique case (st_q)
                    WR_FILL: begin
                        if (wr_end) begin
                            st_q  <= WR_IDLE;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= got;
                        end
                    end
                    WR_SKIP: begin
                        if (wr_end) st_q <= WR_IDLE;
                    end
                    default: st_q <= WR_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rxq_slot_store.sv
module rxq_slot_store
    import rxq_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    parameter int MAX_BYTES = 32,
    parameter int BYTE_W    = 8,
    localparam int IDX_W    = $clog2(MAX_BYTES),
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              byte_we,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              commit,
    input  rxq_desc_t         commit_desc,
    input  logic              rd_next,
    output logic              fifo_full,
    output logic              fifo_empty,
    output rxq_desc_t         head_desc,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_last
);

    logic [BYTE_W-1:0] mem_q [NUM_SLOTS][MAX_BYTES];
    rxq_desc_t         desc_arr [NUM_SLOTS];
    logic [SLOT_W-1:0] wr_slot_q;
    logic [SLOT_W-1:0] rd_slot_q;
    logic [IDX_W-1:0]  rd_idx_q;
    logic [CNT_W-1:0]  count_q;
    logic              pop;
    logic              adv;

    always_ff @(posedge clk) begin
        if (byte_we) begin
            mem_q[wr_slot_q][byte_idx] <= byte_data;
        end
    end

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            rxq_desc_t d_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    d_q <= '0;
                end else if (commit && (int'(wr_slot_q) == s)) begin
                    d_q <= commit_desc;
                end
            end
            assign desc_arr[s] = d_q;
        end
    endgenerate

    always_comb begin
        fifo_empty = (count_q == '0);
        fifo_full  = (count_q == CNT_W'(NUM_SLOTS));
        head_desc  = desc_arr[rd_slot_q];
        rd_last    = !fifo_empty &&
                     ((RXQ_LEN_W'(rd_idx_q) + RXQ_LEN_W'(1)) == head_desc.len);
        rd_data    = fifo_empty ? '0 : mem_q[rd_slot_q][rd_idx_q];
        pop        = rd_next && rd_last;
        adv        = rd_next && !fifo_empty && !rd_last;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_slot_q <= '0;
            rd_slot_q <= '0;
            rd_idx_q  <= '0;
            count_q   <= '0;
        end else begin
            if (commit) begin
                wr_slot_q <= SLOT_W'(rxq_wrap_inc(int'(wr_slot_q), NUM_SLOTS));
            end
            if (pop) begin
                rd_slot_q <= SLOT_W'(rxq_wrap_inc(int'(rd_slot_q), NUM_SLOTS));
                rd_idx_q  <= '0;
            end else if (adv) begin
                rd_idx_q <= rd_idx_q + IDX_W'(1);
            end
            unique case ({commit, pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/rxq_packet_fifo.sv
module rxq_packet_fifo
    import rxq_pkg::*;
#(
    parameter int NUM_PIPES = 6,
    parameter int NUM_SLOTS = 3,
    parameter int MAX_BYTES = 32,
    parameter int BYTE_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  cfg_we,
    input  logic [RXQ_PIPE_W-1:0] cfg_sel,
    input  logic [RXQ_CFG_W-1:0]  cfg_wdata,
    output logic [RXQ_CFG_W-1:0]  cfg_rdata,
    input  logic                  wr_start,
    input  logic [RXQ_PIPE_W-1:0] wr_pipe,
    input  logic                  wr_valid,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  wr_end,
    input  logic                  rd_next,
    output logic                  err_len,
    output logic                  err_ovf,
    output logic                  rx_full,
    output logic                  rx_empty,
    output logic [RXQ_PIPE_W-1:0] rd_pipe,
    output logic [RXQ_LEN_W-1:0]  rd_len,
    output logic [BYTE_W-1:0]     rd_data,
    output logic                  rd_last
);

    localparam int IDX_W = $clog2(MAX_BYTES);

    logic [RXQ_LEN_W-1:0] pipe_len;
    logic                 pipe_known;
    logic                 byte_we;
    logic [IDX_W-1:0]     byte_idx;
    logic [BYTE_W-1:0]    byte_data;
    logic                 commit;
    rxq_desc_t            commit_desc;
    rxq_desc_t            head_desc;

    rxq_width_regs #(
        .NUM_PIPES (NUM_PIPES)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .look_pipe  (wr_pipe),
        .look_len   (pipe_len),
        .look_known (pipe_known)
    );

    rxq_wr_ctrl #(
        .NUM_PIPES (NUM_PIPES),
        .MAX_BYTES (MAX_BYTES),
        .BYTE_W    (BYTE_W)
    ) u_wr (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .wr_start    (wr_start),
        .wr_pipe     (wr_pipe),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .wr_end      (wr_end),
        .pipe_len    (pipe_len),
        .pipe_known  (pipe_known),
        .fifo_full   (rx_full),
        .byte_we     (byte_we),
        .byte_idx    (byte_idx),
        .byte_data   (byte_data),
        .commit      (commit),
        .commit_desc (commit_desc),
        .err_len     (err_len),
        .err_ovf     (err_ovf)
    );

    rxq_slot_store #(
        .NUM_SLOTS (NUM_SLOTS),
        .MAX_BYTES (MAX_BYTES),
        .BYTE_W    (BYTE_W)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .byte_we     (byte_we),
        .byte_idx    (byte_idx),
        .byte_data   (byte_data),
        .commit      (commit),
        .commit_desc (commit_desc),
        .rd_next     (rd_next),
        .fifo_full   (rx_full),
        .fifo_empty  (rx_empty),
        .head_desc   (head_desc),
        .rd_data     (rd_data),
        .rd_last     (rd_last)
    );

    assign rd_pipe = head_desc.pipe;
    assign rd_len  = head_desc.len;

endmodule

// File: rtl/rxq_packet_fifo_chk.sv
module rxq_packet_fifo_chk
    import rxq_pkg::*;
#(
    parameter int MAX_BYTES = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  flush,
    input logic                  rd_next,
    input logic                  err_ovf,
    input logic                  rx_full,
    input logic                  rx_empty,
    input logic [RXQ_PIPE_W-1:0] rd_pipe,
    input logic [RXQ_LEN_W-1:0]  rd_len,
    input logic                  rd_last
);

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(rx_full && rx_empty));

    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
        flush |=> rx_empty);

    assert_ovf_needs_full_R7: assert property (@(posedge clk) disable iff (rst)
        err_ovf |-> $past(rx_full));

    assert_full_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !flush && !rd_next) |=> rx_full);

    assert_partial_keeps_head_R9: assert property (@(posedge clk) disable iff (rst)
        (!rx_empty && rd_next && !rd_last && !flush) |=>
            (!rx_empty && $stable(rd_pipe) && $stable(rd_len)));

    assert_head_len_legal_R2: assert property (@(posedge clk) disable iff (rst)
        !rx_empty |-> ((rd_len != '0) && (int'(rd_len) <= MAX_BYTES)));

endmodule

bind rxq_packet_fifo rxq_packet_fifo_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .rd_next  (rd_next),
    .err_ovf  (err_ovf),
    .rx_full  (rx_full),
    .rx_empty (rx_empty),
    .rd_pipe  (rd_pipe),
    .rd_len   (rd_len),
    .rd_last  (rd_last)
);

// File: tb/rxq_packet_fifo_test.sv
module rxq_packet_fifo_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       wr_start = 1'b0;
    logic [2:0] wr_pipe = '0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_end = 1'b0;
    logic       rd_next = 1'b0;
    logic       err_len, err_ovf, rx_full, rx_empty, rd_last;
    logic [2:0] rd_pipe;
    logic [5:0] rd_len;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    int n_err_len = 0;
    int n_err_ovf = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rxq_packet_fifo uut (
        .clk(clk), .rst(rst), .flush(flush),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .wr_start(wr_start), .wr_pipe(wr_pipe), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_end(wr_end), .rd_next(rd_next), .err_len(err_len), .err_ovf(err_ovf),
        .rx_full(rx_full), .rx_empty(rx_empty), .rd_pipe(rd_pipe), .rd_len(rd_len),
        .rd_data(rd_data), .rd_last(rd_last)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (err_len) n_err_len++;
            if (err_ovf) n_err_ovf++;
        end
    end

    localparam int K_OK = 0, K_TRUNC = 1, K_BADW = 2, K_SHORT = 3;

    typedef struct packed {
        logic [2:0] pipe;
        logic [7:0] sent;
        logic [7:0] exp_len;
        logic [1:0] kind;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{pipe: 3'd0, sent: 8'd1,  exp_len: 8'd1,  kind: 2'(K_OK)},
        '{pipe: 3'd1, sent: 8'd32, exp_len: 8'd32, kind: 2'(K_OK)},
        '{pipe: 3'd2, sent: 8'd7,  exp_len: 8'd5,  kind: 2'(K_TRUNC)},
        '{pipe: 3'd3, sent: 8'd17, exp_len: 8'd17, kind: 2'(K_OK)},
        '{pipe: 3'd4, sent: 8'd3,  exp_len: 8'd0,  kind: 2'(K_BADW)},
        '{pipe: 3'd5, sent: 8'd2,  exp_len: 8'd0,  kind: 2'(K_BADW)},
        '{pipe: 3'd2, sent: 8'd3,  exp_len: 8'd0,  kind: 2'(K_SHORT)},
        '{pipe: 3'd3, sent: 8'd20, exp_len: 8'd17, kind: 2'(K_TRUNC)},
        '{pipe: 3'd6, sent: 8'd4,  exp_len: 8'd0,  kind: 2'(K_BADW)}
    };

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic cfg_write(input int sel, input int val);
        cfg_we = 1'b1;
        cfg_sel = 3'(sel);
        cfg_wdata = 8'(val);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic send(input int pipe, input int n, input int base);
        wr_start = 1'b1;
        wr_pipe = 3'(pipe);
        step();
        wr_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1;
            wr_data = 8'((base + i) & 255);
            wr_end = (i == n - 1);
            step();
        end
        wr_valid = 1'b0;
        wr_end = 1'b0;
    endtask

    task automatic read_bytes(input string tag, input int len, input int base,
                              input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            chk({tag, " R8 data"}, int'(rd_data), (base + i) & 255);
            chk({tag, " R8 last"}, int'(rd_last), (i == len - 1) ? 1 : 0);
            rd_next = 1'b1;
            step();
            rd_next = 1'b0;
        end
    endtask

    task automatic read_pkt(input string tag, input int pipe, input int len, input int base);
        chk({tag, " R6 not empty"}, int'(rx_empty), 0);
        chk({tag, " R8 head pipe"}, int'(rd_pipe), pipe);
        chk({tag, " R2 head len"}, int'(rd_len), len);
        read_bytes(tag, len, base, 0, len);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int e0;
        int base;
        repeat (3) step();
        rst = 1'b0;
        step();

        // Reset state (R6, R1, R12)
        chk("R6 reset empty", int'(rx_empty), 1);
        chk("R6 reset full", int'(rx_full), 0);
        chk("R6 reset err_len", int'(err_len), 0);
        chk("R6 reset err_ovf", int'(err_ovf), 0);
        chk("R12 empty rd_data", int'(rd_data), 0);
        cfg_sel = 3'd3;
        #1;
        chk("R1 reset width", int'(cfg_rdata), 0);

        // R1: reserved bits and out-of-range select
        cfg_write(2, 8'hFF);
        cfg_sel = 3'd2;
        #1;
        chk("R1 reserved bits zero", int'(cfg_rdata), 8'h3F);
        cfg_write(7, 8'h11);
        cfg_sel = 3'd7;
        #1;
        chk("R1 select 7 reads 0", int'(cfg_rdata), 0);
        cfg_sel = 3'd0;
        #1;
        chk("R1 pipe0 untouched", int'(cfg_rdata), 0);

        cfg_write(0, 1);
        cfg_write(1, 32);
        cfg_write(2, 8'hC5);
        cfg_write(3, 17);
        cfg_write(5, 40);
        cfg_sel = 3'd2;
        #1;
        chk("R1 upper bits dropped", int'(cfg_rdata), 5);
        cfg_sel = 3'd5;
        #1;
        chk("R1 pipe5 width", int'(cfg_rdata), 40);

        // Vector table: R2 R3 R4 R5
        for (int k = 0; k < 9; k++) begin
            base = (k * 37 + 3) & 255;
            e0 = n_err_len;
            send(int'(VECS[k].pipe), int'(VECS[k].sent), base);
            step();
            case (int'(VECS[k].kind))
                K_OK: begin
                    chk("R2 no error", n_err_len - e0, 0);
                    read_pkt("R2 table", int'(VECS[k].pipe), int'(VECS[k].exp_len), base);
                end
                K_TRUNC: begin
                    chk("R3 no error", n_err_len - e0, 0);
                    read_pkt("R3 table", int'(VECS[k].pipe), int'(VECS[k].exp_len), base);
                end
                K_BADW: begin
                    chk("R4 err_len pulse", n_err_len - e0, 1);
                    chk("R4 dropped", int'(rx_empty), 1);
                end
                default: begin
                    chk("R5 err_len pulse", n_err_len - e0, 1);
                    chk("R5 dropped", int'(rx_empty), 1);
                end
            endcase
            chk("R6 empty after table entry", int'(rx_empty), 1);
        end

        // R6 R7 R9 R10: fill, overflow, partial read, order
        send(3, 17, 8'h40);
        chk("R6 one stored empty", int'(rx_empty), 0);
        chk("R6 one stored full", int'(rx_full), 0);
        send(0, 1, 8'h90);
        send(2, 5, 8'hA0);
        chk("R6 three stored full", int'(rx_full), 1);
        e0 = n_err_ovf;
        send(1, 32, 8'hC0);
        step();
        chk("R7 err_ovf pulse", n_err_ovf - e0, 1);
        chk("R7 still full", int'(rx_full), 1);
        chk("R7 head pipe kept", int'(rd_pipe), 3);
        read_bytes("R9 partial", 17, 8'h40, 0, 4);
        chk("R9 head kept pipe", int'(rd_pipe), 3);
        chk("R9 head kept len", int'(rd_len), 17);
        chk("R9 position kept", int'(rd_data), 8'h44);
        chk("R9 not popped", int'(rx_full), 1);
        read_bytes("R9 rest", 17, 8'h40, 4, 17);
        chk("R6 full clears after pop", int'(rx_full), 0);
        read_pkt("R10 second", 0, 1, 8'h90);
        read_pkt("R10 third", 2, 5, 8'hA0);
        chk("R10 drained", int'(rx_empty), 1);

        // R12: read strobe while empty
        rd_next = 1'b1;
        step();
        step();
        rd_next = 1'b0;
        chk("R12 still empty", int'(rx_empty), 1);
        send(2, 5, 8'h60);
        read_pkt("R12 after empty reads", 2, 5, 8'h60);

        // R11: flush during capture
        e0 = n_err_len;
        wr_start = 1'b1;
        wr_pipe = 3'd3;
        step();
        wr_start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            wr_valid = 1'b1;
            wr_data = 8'(i);
            step();
        end
        wr_valid = 1'b0;
        flush = 1'b1;
        step();
        flush = 1'b0;
        for (int i = 5; i < 17; i++) begin
            wr_valid = 1'b1;
            wr_data = 8'(i);
            wr_end = (i == 16);
            step();
        end
        wr_valid = 1'b0;
        wr_end = 1'b0;
        step();
        chk("R11 aborted capture empty", int'(rx_empty), 1);
        chk("R11 aborted capture no error", n_err_len - e0, 0);

        // R11: flush with stored packets and partial read
        send(2, 5, 8'h10);
        send(3, 17, 8'h20);
        read_bytes("R11 pre-flush", 5, 8'h10, 0, 2);
        flush = 1'b1;
        step();
        flush = 1'b0;
        chk("R11 flush empty", int'(rx_empty), 1);
        chk("R11 flush not full", int'(rx_full), 0);
        send(2, 5, 8'h70);
        read_pkt("R11 after flush", 2, 5, 8'h70);

        // R11: flush in the same cycle as a commit
        wr_start = 1'b1;
        wr_pipe = 3'd0;
        step();
        wr_start = 1'b0;
        wr_valid = 1'b1;
        wr_data = 8'h33;
        wr_end = 1'b1;
        flush = 1'b1;
        step();
        wr_valid = 1'b0;
        wr_end = 1'b0;
        flush = 1'b0;
        step();
        chk("R11 flush beats commit", int'(rx_empty), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule